// File: doc/BRIEF.md
# Postfix Token Stack Evaluator

This block computes the value of an integer arithmetic expression that arrives as postfix (reverse Polish) tokens. A token is an operand value, an operator (add, subtract or multiply) or an end marker. Operands go onto an internal last-in-first-out stack. For each operator, a small controller takes the two most recent entries off the stack one at a time, combines them and pushes the result back. When the end marker arrives, a lone remaining entry is reported as the result.

Tokens enter through a valid/ready handshake. The controller holds ready low while it works through an operator. Three one-cycle error pulses flag misuse: an operator with too few entries, an operand pushed onto a full stack, and an end marker that leaves some count of entries other than one. Every end marker empties the stack, so the next expression starts from nothing. The data width and the stack depth are parameters. All arithmetic wraps modulo 2^W.

Top module: `pfx_eval`

## Requirements
- R1: A token is accepted on a rising edge where `tok_valid` and `tok_ready` are both high. Each token's type is set by `tok_kind`: 0 is an operand, 1 is an operator, 2 is the end marker and 3 is a no-op. An accepted operand is pushed. An accepted end marker with exactly one entry on the stack raises `res_valid` for one cycle, starting the cycle after acceptance, and `res_data` then carries that entry.
- R2: Operator code 0 (`tok_op`) adds the two top entries, and the sum wraps modulo 2^W.
- R3: Operator code 1 subtracts. The result is the entry pushed earlier minus the entry pushed later (second popped minus first popped), modulo 2^W.
- R4: Operator code 2 multiplies, and only the low W bits of the product are kept.
- R5: Operator code 3 behaves exactly like code 0 (addition).
- R6: After an operator is accepted with at least two entries on the stack, `tok_ready` is low for exactly the next three cycles and then returns high. At every other time outside reset, `tok_ready` is high.
- R7: An operator accepted with fewer than two entries on the stack pulses `err_underflow` in the next cycle. The stack is left unchanged and `tok_ready` stays high.
- R8: An operand accepted while the stack already holds DEPTH entries pulses `err_overflow` in the next cycle. The operand is discarded and the stack is left unchanged.
- R9: An end marker accepted with a count other than one pulses `err_malformed` in the next cycle, and `res_valid` stays low.
- R10: Every accepted end marker empties the stack, whether the expression was well formed or not, so the next expression is evaluated independently.
- R11: After reset, `tok_ready` is high, all pulse outputs are low and the stack is empty.
- R12: An accepted token of kind 3 changes nothing: no push, no pop and no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Block can take a token this cycle |
| tok_kind | input | 2 | 0 operand, 1 operator, 2 end marker, 3 no-op |
| tok_op | input | 2 | Operator code: 0 add, 1 subtract, 2 multiply, 3 add |
| tok_data | input | W | Operand value |
| res_valid | output | 1 | One-cycle pulse: result available |
| res_data | output | W | Result value, meaningful while `res_valid` is high |
| err_underflow | output | 1 | One-cycle pulse: operator lacked two entries |
| err_overflow | output | 1 | One-cycle pulse: operand pushed onto a full stack |
| err_malformed | output | 1 | One-cycle pulse: end marker with a count other than one |

## Verification
The assertions assume the token fields stay stable for as long as `tok_valid` is high. They also assume that the stack count the controller reads is the same count the storage holds, so a pop is never requested on an empty stack while an operator is in flight. The bench drives tokens only on falling edges and holds each one until a rising edge where ready was high. It often presents the next token while an operator is still in flight, which exercises the stall without ever changing a token before it has been taken. A behavioural queue model predicts ready, the result and every error pulse, and these are compared with the design on every cycle.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [1:0] {
        TK_OPERAND  = 2'd0,
        TK_OPERATOR = 2'd1,
        TK_END      = 2'd2,
        TK_NOP      = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        OP_ADD     = 2'd0,
        OP_SUB     = 2'd1,
        OP_MUL     = 2'd2,
        OP_ADD_ALT = 2'd3
    } op_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POP_RHS,
        ST_POP_LHS,
        ST_PUSH
    } ctrl_state_e;

endpackage

// File: rtl/pfx_alu.sv
module pfx_alu #(
    parameter int W = 16
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);
    import pfx_pkg::*;

    always_comb begin
        case (op_code_e'(op))
            OP_SUB:  res = lhs - rhs;
            OP_MUL:  res = lhs * rhs;
            default: res = lhs + rhs;
        endcase
    end

endmodule

// File: rtl/pfx_stack.sv
module pfx_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clear,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  top,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t          stk_d, stk_q;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;
    logic          wr_en;

    assign wr_idx = AW'(stk_q.cnt);
    assign rd_idx = AW'(stk_q.cnt - 1'b1);
    assign wr_en  = push && !clear && (stk_q.cnt < CW'(DEPTH));

    always_comb begin
        stk_d = stk_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_idx == AW'(i))) begin
                stk_d.mem[i] = wdata;
            end
        end
        if (clear) begin
            stk_d.cnt = '0;
        end else if (wr_en) begin
            stk_d.cnt = stk_q.cnt + 1'b1;
        end else if (pop && (stk_q.cnt != '0)) begin
            stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign top   = (stk_q.cnt == '0) ? '0 : stk_q.mem[rd_idx];
    assign count = stk_q.cnt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R10

    AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear && !pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH))); // R8

endmodule

// File: rtl/pfx_ctrl.sv
module pfx_ctrl #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_valid,
    output logic          tok_ready,
    input  logic [1:0]    tok_kind,
    input  logic [1:0]    tok_op,
    input  logic [W-1:0]  tok_data,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  top,
    input  logic [W-1:0]  alu_res,
    output logic          push,
    output logic          pop,
    output logic          clear,
    output logic [W-1:0]  wdata,
    output logic [1:0]    op_sel,
    output logic [W-1:0]  lhs,
    output logic [W-1:0]  rhs,
    output logic          res_valid,
    output logic [W-1:0]  res_data,
    output logic          err_underflow,
    output logic          err_overflow,
    output logic          err_malformed
);
    import pfx_pkg::*;

    typedef struct packed {
        ctrl_state_e state;
        logic [1:0]  op;
        logic [W-1:0] lhs;
        logic [W-1:0] rhs;
        logic        rv;
        logic [W-1:0] rd;
        logic        uf;
        logic        of;
        logic        mf;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  acc;

    assign tok_ready = (c_q.state == ST_IDLE);
    assign acc       = tok_valid && tok_ready;

    always_comb begin
        c_d    = c_q;
        c_d.rv = 1'b0;
        c_d.uf = 1'b0;
        c_d.of = 1'b0;
        c_d.mf = 1'b0;
        push   = 1'b0;
        pop    = 1'b0;
        clear  = 1'b0;
        wdata  = tok_data;
        case (c_q.state)
            ST_IDLE: begin
                if (acc) begin
                    case (tok_kind_e'(tok_kind))
                        TK_OPERAND: begin
                            if (count == CW'(DEPTH)) begin
                                c_d.of = 1'b1;
                            end else begin
                                push = 1'b1;
                            end
                        end
                        TK_OPERATOR: begin
                            if (count < CW'(2)) begin
                                c_d.uf = 1'b1;
                            end else begin
                                c_d.op    = tok_op;
                                c_d.state = ST_POP_RHS;
                            end
                        end
                        TK_END: begin
                            if (count == CW'(1)) begin
                                c_d.rv = 1'b1;
                                c_d.rd = top;
                            end else begin
                                c_d.mf = 1'b1;
                            end
                            clear = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_POP_RHS: begin
                c_d.rhs   = top;
                pop       = 1'b1;
                c_d.state = ST_POP_LHS;
            end
            ST_POP_LHS: begin
                c_d.lhs   = top;
                pop       = 1'b1;
                c_d.state = ST_PUSH;
            end
            ST_PUSH: begin
                push      = 1'b1;
                wdata     = alu_res;
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign op_sel        = c_q.op;
    assign lhs           = c_q.lhs;
    assign rhs           = c_q.rhs;
    assign res_valid     = c_q.rv;
    assign res_data      = c_q.rd;
    assign err_underflow = c_q.uf;
    assign err_overflow  = c_q.of;
    assign err_malformed = c_q.mf;

    AST_OPER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && tok_kind == 2'd1 && count >= CW'(2)) |=> !tok_ready); // R6

    AST_SHORT_OPER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && tok_kind == 2'd1 && count < CW'(2)) |=> (count == $past(count) && tok_ready && err_underflow)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && tok_kind == 2'd0 && count == CW'(DEPTH)) |=> (count == $past(count) && err_overflow)); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && err_malformed)); // R9

    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && tok_kind == 2'd2 && count == CW'(1)) |=> res_valid); // R1

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && tok_kind == 2'd3) |=> (count == $past(count) && tok_ready)); // R12

endmodule

// File: rtl/pfx_eval.sv
module pfx_eval #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tok_valid,
    output logic         tok_ready,
    input  logic [1:0]   tok_kind,
    input  logic [1:0]   tok_op,
    input  logic [W-1:0] tok_data,
    output logic         res_valid,
    output logic [W-1:0] res_data,
    output logic         err_underflow,
    output logic         err_overflow,
    output logic         err_malformed
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop, clear;
    logic [W-1:0]  wdata, top, alu_res, lhs, rhs;
    logic [CW-1:0] count;
    logic [1:0]    op_sel;

    pfx_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tok_valid     (tok_valid),
        .tok_ready     (tok_ready),
        .tok_kind      (tok_kind),
        .tok_op        (tok_op),
        .tok_data      (tok_data),
        .count         (count),
        .top           (top),
        .alu_res       (alu_res),
        .push          (push),
        .pop           (pop),
        .clear         (clear),
        .wdata         (wdata),
        .op_sel        (op_sel),
        .lhs           (lhs),
        .rhs           (rhs),
        .res_valid     (res_valid),
        .res_data      (res_data),
        .err_underflow (err_underflow),
        .err_overflow  (err_overflow),
        .err_malformed (err_malformed)
    );

    pfx_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .clear (clear),
        .wdata (wdata),
        .top   (top),
        .count (count)
    );

    pfx_alu #(.W(W)) u_alu (
        .op  (op_sel),
        .lhs (lhs),
        .rhs (rhs),
        .res (alu_res)
    );

endmodule

// File: tb/pfx_eval_tb.sv
`timescale 1ns/1ps
module pfx_eval_tb;
    localparam int W     = 16;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tok_valid;
    logic         tok_ready;
    logic [1:0]   tok_kind;
    logic [1:0]   tok_op;
    logic [W-1:0] tok_data;
    logic         res_valid;
    logic [W-1:0] res_data;
    logic         err_underflow, err_overflow, err_malformed;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pfx_eval #(.W(W), .DEPTH(DEPTH)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tok_valid     (tok_valid),
        .tok_ready     (tok_ready),
        .tok_kind      (tok_kind),
        .tok_op        (tok_op),
        .tok_data      (tok_data),
        .res_valid     (res_valid),
        .res_data      (res_data),
        .err_underflow (err_underflow),
        .err_overflow  (err_overflow),
        .err_malformed (err_malformed)
    );

    // behavioural reference model
    logic [W-1:0] m_stk[$];
    int           m_busy;
    logic         m_rv, m_uf, m_of, m_mf, m_take;
    logic [W-1:0] m_rd, m_l, m_r, m_v;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stk.delete();
            m_busy = 0;
            m_rv = 0; m_uf = 0; m_of = 0; m_mf = 0; m_rd = '0;
        end else begin
            m_take = tok_valid && (m_busy == 0);
            m_rv = 0; m_uf = 0; m_of = 0; m_mf = 0;
            if (m_busy > 0) m_busy = m_busy - 1;
            if (m_take) begin
                case (tok_kind)
                    2'd0: begin
                        if (m_stk.size() == DEPTH) m_of = 1;
                        else m_stk.push_back(tok_data);
                    end
                    2'd1: begin
                        if (m_stk.size() < 2) m_uf = 1;
                        else begin
                            m_r = m_stk.pop_back();
                            m_l = m_stk.pop_back();
                            case (tok_op)
                                2'd1:    m_v = m_l - m_r;
                                2'd2:    m_v = m_l * m_r;
                                default: m_v = m_l + m_r;
                            endcase
                            m_stk.push_back(m_v);
                            m_busy = 3;
                        end
                    end
                    2'd2: begin
                        if (m_stk.size() == 1) begin
                            m_rv = 1;
                            m_rd = m_stk[0];
                        end else m_mf = 1;
                        m_stk.delete();
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 tok_ready", W'(tok_ready), W'(m_busy == 0));
            chk("R1/R9 res_valid", W'(res_valid), W'(m_rv));
            if (m_rv) chk({cur_req, " res_data"}, res_data, m_rd);
            chk("R7 err_underflow", W'(err_underflow), W'(m_uf));
            chk("R8 err_overflow", W'(err_overflow), W'(m_of));
            chk("R9 err_malformed", W'(err_malformed), W'(m_mf));
        end
    end

    task automatic send(input logic [1:0] kind, input logic [1:0] op, input logic [W-1:0] data);
        logic got;
        tok_valid = 1'b1;
        tok_kind  = kind;
        tok_op    = op;
        tok_data  = data;
        forever begin
            got = tok_ready;
            @(posedge clk);
            @(negedge clk);
            if (got) break;
        end
        tok_valid = 1'b0;
    endtask

    task automatic opnd(input logic [W-1:0] v); send(2'd0, 2'd0, v); endtask
    task automatic oper(input logic [1:0] o);   send(2'd1, o, '0);    endtask
    task automatic idle(input int n); tok_valid = 1'b0; repeat (n) @(negedge clk); endtask
    task automatic fin(); send(2'd2, 2'd0, '0); idle(2); endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; tok_valid = 1'b0; tok_kind = '0; tok_op = '0; tok_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 tok_ready", W'(tok_ready), W'(1));
        chk("R11 res_valid", W'(res_valid), W'(0));
        chk("R11 errors", W'({err_underflow, err_overflow, err_malformed}), W'(0));
        fin(); // R11: empty stack gives malformed, not a result

        cur_req = "R1"; // (3+4)*5 = 35
        opnd(3); opnd(4); oper(0); opnd(5); oper(2); fin();
        chk("R1 explicit", m_rd, 16'd35);

        cur_req = "R2"; // wrap on add
        opnd(16'hFFF0); opnd(16'h0020); oper(0); fin();

        cur_req = "R3"; // 3 - 10 = -7
        opnd(3); opnd(10); oper(1); fin();
        chk("R3 explicit", m_rd, 16'hFFF9);

        cur_req = "R4"; // 300*300 mod 65536 = 24464
        opnd(300); opnd(300); oper(2); fin();
        chk("R4 explicit", m_rd, 16'd24464);

        cur_req = "R5"; // op 3 behaves as add
        opnd(11); opnd(22); oper(3); fin();

        cur_req = "R7"; // underflow leaves stack alone
        oper(0); opnd(7); oper(1); opnd(2); oper(0); fin();
        oper(2); fin(); // R9 on empty stack after underflow

        cur_req = "R8"; // overflow on ninth operand
        for (int i = 1; i <= DEPTH; i++) opnd(W'(i));
        opnd(99);
        for (int i = 1; i < DEPTH; i++) oper(0);
        fin();
        chk("R8 explicit sum", m_rd, 16'd36);

        cur_req = "R10"; // malformed then fresh expression
        opnd(1); opnd(2); fin();
        opnd(5); fin();

        cur_req = "R12"; // no-op token ignored
        opnd(4); send(2'd3, 2'd2, 16'd77); opnd(6); oper(1); fin();
        chk("R12 explicit", m_rd, 16'hFFFE);

        cur_req = "R6"; // chained operators keep ready stalling correctly
        opnd(2); opnd(3); opnd(4); oper(2); oper(2); fin();
        idle(4);
        finish_run();
    end

endmodule